// File: doc/BRIEF.md
# Dual-Issue Instruction Scheduler with Look-Ahead Window

The scheduler accepts decoded instructions, one per cycle, over a valid/ready stream and keeps them in a small window in program order. In every cycle it issues up to two of them to two execution slots. Slot 0 always takes the oldest instruction that can go. Slot 1 takes the oldest younger instruction that has no hazard with anything older that is still waiting. Because of this look-ahead, a blocked second instruction does not stop a later independent one from pairing with the oldest. Issued entries leave the window and the survivors close up in their original order.

Each instruction names one destination and two source registers, a floating-point flag, a branch flag and an opaque tag. The tag is returned on the slot that issues the instruction. The hazards checked are: a read after an unissued write, writes that would overtake older reads or writes of the same register, two floating-point operations competing for the single shared unit, and control flow past a branch. Once a branch issues, nothing more issues until a resolve pulse arrives. Two saturating counters record cycles in which the window held work but issued nothing, and cycles in which only one slot was filled.

The input stream obeys valid/ready rules. An instruction transfers on a clock edge where both valid and ready are high. Ready depends only on how full the window is, so the source may hold valid high while ready is low and nothing is lost or taken. Branch resolve and the two counters are plain signals.

Top module: `dual_issue_sched`

## Requirements
- R1: At most two instructions issue per cycle. Slot 1 is never valid without slot 0. Whenever issue is allowed, slot 0 carries the oldest window entry, and slot 1 carries an instruction younger than the one in slot 0.
- R2: An instruction that reads a register written by an older unissued entry does not issue in the same cycle as that entry, and issues at the earliest in the following cycle. Register number 0 means "no register" and never creates a dependency.
- R3: A younger instruction is not picked while its destination register matches a source or the destination of an older unissued entry. Both comparisons ignore register 0.
- R4: Two instructions with the floating-point flag set never issue in the same cycle, even when they share no register.
- R5: When entry 1 is blocked, slot 1 takes the oldest hazard-free entry from position 2 onward.
- R6: No instruction issues before, or together with, an older branch still in the window. After a branch issues, nothing issues until a `br_resolve` pulse; issue resumes in the cycle after that pulse.
- R7: At each clock edge, `vwaste_cnt` increments by one when the window was non-empty and no instruction issued in that cycle. It saturates at all ones.
- R8: At each clock edge, `hwaste_cnt` increments by one when exactly one instruction issued in that cycle. It saturates at all ones.
- R9: `in_ready` is high exactly when fewer than DEPTH entries are held. One instruction is accepted per edge with `in_valid` and `in_ready` high. An offered instruction is not taken while `in_ready` is low.
- R10: After reset the window is empty, no branch is pending, neither slot is valid, `in_ready` is high and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Decode side offers an instruction |
| in_ready | output | 1 | Window has a free entry |
| in_dst | input | REG_W | Destination register, 0 = none |
| in_src_a | input | REG_W | First source register, 0 = none |
| in_src_b | input | REG_W | Second source register, 0 = none |
| in_fp | input | 1 | Needs the shared floating-point unit |
| in_br | input | 1 | Instruction is a branch |
| in_tag | input | TAG_W | Identifier returned on issue |
| br_resolve | input | 1 | One-cycle pulse resolving the issued branch |
| iss0_vld | output | 1 | Slot 0 issues this cycle |
| iss0_tag | output | TAG_W | Tag of the slot 0 instruction |
| iss1_vld | output | 1 | Slot 1 issues this cycle |
| iss1_tag | output | TAG_W | Tag of the slot 1 instruction |
| vwaste_cnt | output | CNT_W | Cycles with work waiting but no issue |
| hwaste_cnt | output | CNT_W | Cycles with exactly one issue |

## Verification
The bench builds the block with DEPTH=4, REG_W=5, TAG_W=4 and CNT_W=6. Four-bit tags let each issue cycle's expected slot pair fit in one byte of a vector table. Six-bit counters reach saturation within about seventy stalled or single-issue cycles, so both saturation limits can be tested. A held branch keeps the full four-entry window frozen while a group of instructions is loaded, which makes every pairing, look-ahead and back-pressure case start from the same known window contents.

// File: rtl/sched_pkg.sv
package sched_pkg;

  // Number of issue slots served per cycle.
  localparam int unsigned NUM_SLOTS = 2;

  // How many slots were filled in a cycle; drives waste accounting.
  typedef enum logic [1:0] {
    FILL_NONE = 2'd0,
    FILL_HALF = 2'd1,
    FILL_FULL = 2'd2
  } slot_fill_e;

endpackage

// File: rtl/sched_window.sv
// Program-ordered instruction window with compaction on issue.
module sched_window #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned REG_W = 5,
  parameter int unsigned TAG_W = 6,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned POS_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [REG_W-1:0]            push_dst,
  input  logic [REG_W-1:0]            push_sa,
  input  logic [REG_W-1:0]            push_sb,
  input  logic                        push_fp,
  input  logic                        push_br,
  input  logic [TAG_W-1:0]            push_tag,
  input  logic [DEPTH-1:0]            take,
  output logic [POS_W-1:0]            count_q,
  output logic [DEPTH-1:0]            vld,
  output logic [DEPTH-1:0][REG_W-1:0] dst_q,
  output logic [DEPTH-1:0][REG_W-1:0] sa_q,
  output logic [DEPTH-1:0][REG_W-1:0] sb_q,
  output logic [DEPTH-1:0]            fp_q,
  output logic [DEPTH-1:0]            br_q,
  output logic [DEPTH-1:0][TAG_W-1:0] tag_q
);

  logic [POS_W-1:0]            count_d;
  logic [DEPTH-1:0][REG_W-1:0] dst_d, sa_d, sb_d;
  logic [DEPTH-1:0]            fp_d, br_d;
  logic [DEPTH-1:0][TAG_W-1:0] tag_d;
  logic [POS_W-1:0]            pos;

  for (genvar g = 0; g < DEPTH; g++) begin : g_vld
    assign vld[g] = (count_q > POS_W'(g));
  end

  // Survivors move down to the lowest free slots, then the new entry lands behind them.
  always_comb begin
    dst_d = dst_q;
    sa_d  = sa_q;
    sb_d  = sb_q;
    fp_d  = fp_q;
    br_d  = br_q;
    tag_d = tag_q;
    pos   = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (vld[j] && !take[j]) begin
        dst_d[pos[IDX_W-1:0]] = dst_q[j];
        sa_d[pos[IDX_W-1:0]]  = sa_q[j];
        sb_d[pos[IDX_W-1:0]]  = sb_q[j];
        fp_d[pos[IDX_W-1:0]]  = fp_q[j];
        br_d[pos[IDX_W-1:0]]  = br_q[j];
        tag_d[pos[IDX_W-1:0]] = tag_q[j];
        pos = pos + 1'b1;
      end
    end
    count_d = pos;
    if (push && (pos < POS_W'(DEPTH))) begin
      dst_d[pos[IDX_W-1:0]] = push_dst;
      sa_d[pos[IDX_W-1:0]]  = push_sa;
      sb_d[pos[IDX_W-1:0]]  = push_sb;
      fp_d[pos[IDX_W-1:0]]  = push_fp;
      br_d[pos[IDX_W-1:0]]  = push_br;
      tag_d[pos[IDX_W-1:0]] = push_tag;
      count_d = pos + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      dst_q   <= '0;
      sa_q    <= '0;
      sb_q    <= '0;
      fp_q    <= '0;
      br_q    <= '0;
      tag_q   <= '0;
    end else begin
      count_q <= count_d;
      dst_q   <= dst_d;
      sa_q    <= sa_d;
      sb_q    <= sb_d;
      fp_q    <= fp_d;
      br_q    <= br_d;
      tag_q   <= tag_d;
    end
  end

endmodule

// File: rtl/sched_hazard.sv
// Pairwise hazard matrix: entry j is ready when no older waiting entry blocks it.
module sched_hazard #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned REG_W = 5
) (
  input  logic [DEPTH-1:0]            vld,
  input  logic [DEPTH-1:0][REG_W-1:0] dst,
  input  logic [DEPTH-1:0][REG_W-1:0] sa,
  input  logic [DEPTH-1:0][REG_W-1:0] sb,
  input  logic [DEPTH-1:0]            br,
  input  logic                        br_pend,
  output logic [DEPTH-1:0]            ready
);

  function automatic logic same_reg(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b);
    return (a != '0) && (a == b);
  endfunction

  logic [DEPTH-1:0][DEPTH-1:0] blk;

  for (genvar j = 0; j < DEPTH; j++) begin : g_young
    for (genvar k = 0; k < DEPTH; k++) begin : g_old
      if (k < j) begin : g_pair
        logic raw, war, waw;
        assign raw = same_reg(dst[k], sa[j]) || same_reg(dst[k], sb[j]);
        assign war = same_reg(dst[j], sa[k]) || same_reg(dst[j], sb[k]);
        assign waw = same_reg(dst[j], dst[k]);
        assign blk[j][k] = vld[k] && (br[k] || raw || war || waw);
      end else begin : g_none
        assign blk[j][k] = 1'b0;
      end
    end
    assign ready[j] = vld[j] && !br_pend && !(|blk[j]);
  end

endmodule

// File: rtl/sched_pick.sv
// Oldest-first slot selection with the shared floating-point unit as a pairing limit.
module sched_pick #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] ready,
  input  logic [DEPTH-1:0] fp,
  output logic             s0_vld,
  output logic [IDX_W-1:0] idx0,
  output logic             s1_vld,
  output logic [IDX_W-1:0] idx1,
  output logic [DEPTH-1:0] take
);

  always_comb begin
    s0_vld = 1'b0;
    idx0   = '0;
    s1_vld = 1'b0;
    idx1   = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (!s0_vld && ready[j]) begin
        s0_vld = 1'b1;
        idx0   = IDX_W'(j);
      end
    end
    for (int j = 0; j < DEPTH; j++) begin
      if (s0_vld && !s1_vld && ready[j] && (IDX_W'(j) > idx0) && !(fp[idx0] && fp[j])) begin
        s1_vld = 1'b1;
        idx1   = IDX_W'(j);
      end
    end
    take = '0;
    if (s0_vld) take[idx0] = 1'b1;
    if (s1_vld) take[idx1] = 1'b1;
  end

endmodule

// File: rtl/sched_sat_ctr.sv
// Saturating event counter.
module sched_sat_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (inc && (cnt != '1)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dual_issue_sched.sv
module dual_issue_sched
  import sched_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned REG_W = 5,
  parameter int unsigned TAG_W = 6,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src_a,
  input  logic [REG_W-1:0] in_src_b,
  input  logic             in_fp,
  input  logic             in_br,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             br_resolve,
  output logic             iss0_vld,
  output logic [TAG_W-1:0] iss0_tag,
  output logic             iss1_vld,
  output logic [TAG_W-1:0] iss1_tag,
  output logic [CNT_W-1:0] vwaste_cnt,
  output logic [CNT_W-1:0] hwaste_cnt
);

  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned POS_W = $clog2(DEPTH + 1);

  logic [POS_W-1:0]            count_q;
  logic [DEPTH-1:0]            vld;
  logic [DEPTH-1:0][REG_W-1:0] dst_q, sa_q, sb_q;
  logic [DEPTH-1:0]            fp_q, br_q;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q;
  logic [DEPTH-1:0]            ready, take;
  logic                        s0_vld, s1_vld;
  logic [IDX_W-1:0]            idx0, idx1;
  logic                        br_pend_q, br_issued;
  logic                        push;
  logic                        slot0_fp, slot1_fp;
  slot_fill_e                  fill;

  assign in_ready = (count_q < POS_W'(DEPTH));
  assign push     = in_valid && in_ready;

  sched_window #(.DEPTH(DEPTH), .REG_W(REG_W), .TAG_W(TAG_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_dst (in_dst),
    .push_sa  (in_src_a),
    .push_sb  (in_src_b),
    .push_fp  (in_fp),
    .push_br  (in_br),
    .push_tag (in_tag),
    .take     (take),
    .count_q  (count_q),
    .vld      (vld),
    .dst_q    (dst_q),
    .sa_q     (sa_q),
    .sb_q     (sb_q),
    .fp_q     (fp_q),
    .br_q     (br_q),
    .tag_q    (tag_q)
  );

  sched_hazard #(.DEPTH(DEPTH), .REG_W(REG_W)) u_haz (
    .vld     (vld),
    .dst     (dst_q),
    .sa      (sa_q),
    .sb      (sb_q),
    .br      (br_q),
    .br_pend (br_pend_q),
    .ready   (ready)
  );

  sched_pick #(.DEPTH(DEPTH)) u_pick (
    .ready  (ready),
    .fp     (fp_q),
    .s0_vld (s0_vld),
    .idx0   (idx0),
    .s1_vld (s1_vld),
    .idx1   (idx1),
    .take   (take)
  );

  assign iss0_vld = s0_vld;
  assign iss1_vld = s1_vld;
  assign iss0_tag = tag_q[idx0];
  assign iss1_tag = tag_q[idx1];
  assign slot0_fp = s0_vld && fp_q[idx0];
  assign slot1_fp = s1_vld && fp_q[idx1];

  // A branch leaving the window freezes issue until its resolve pulse.
  assign br_issued = (s0_vld && br_q[idx0]) || (s1_vld && br_q[idx1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br_pend_q <= 1'b0;
    end else if (br_issued) begin
      br_pend_q <= 1'b1;
    end else if (br_resolve) begin
      br_pend_q <= 1'b0;
    end
  end

  always_comb begin
    if (s0_vld && s1_vld) fill = FILL_FULL;
    else if (s0_vld)      fill = FILL_HALF;
    else                  fill = FILL_NONE;
  end

  sched_sat_ctr #(.CNT_W(CNT_W)) u_vwaste (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   ((fill == FILL_NONE) && (count_q != '0)),
    .cnt   (vwaste_cnt)
  );

  sched_sat_ctr #(.CNT_W(CNT_W)) u_hwaste (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (fill == FILL_HALF),
    .cnt   (hwaste_cnt)
  );

endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned POS_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss0_vld,
  input logic             iss1_vld,
  input logic             slot0_fp,
  input logic             slot1_fp,
  input logic             br_pend,
  input logic [POS_W-1:0] occ,
  input logic [CNT_W-1:0] vwaste,
  input logic [CNT_W-1:0] hwaste
);

  // R1
  a_r1_slot1_needs_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    iss1_vld |-> iss0_vld);

  // R4
  a_r4_single_fp_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (iss0_vld && iss1_vld) |-> !(slot0_fp && slot1_fp));

  // R6
  a_r6_frozen_after_branch: assert property (@(posedge clk) disable iff (!rst_n)
    br_pend |-> !iss0_vld);

  // R9
  a_r9_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= POS_W'(DEPTH));

  // R9
  a_r9_one_push_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, occ} <= {1'b0, $past(occ)} + 1'b1));

  // R7
  a_r7_vwaste_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((vwaste == $past(vwaste)) || (vwaste == $past(vwaste) + 1'b1)));

  // R7
  a_r7_vwaste_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss0_vld && (occ != '0) && (vwaste != '1)) |=> (vwaste == $past(vwaste) + 1'b1));

  // R8
  a_r8_hwaste_on_single: assert property (@(posedge clk) disable iff (!rst_n)
    (iss0_vld && !iss1_vld && (hwaste != '1)) |=> (hwaste == $past(hwaste) + 1'b1));

  // R8
  a_r8_hwaste_hold_on_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (iss0_vld && iss1_vld) |=> $stable(hwaste));

endmodule

bind dual_issue_sched sched_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .iss0_vld (iss0_vld),
  .iss1_vld (iss1_vld),
  .slot0_fp (slot0_fp),
  .slot1_fp (slot1_fp),
  .br_pend  (br_pend_q),
  .occ      (count_q),
  .vwaste   (vwaste_cnt),
  .hwaste   (hwaste_cnt)
);

// File: tb/dual_issue_sched_test.sv
module dual_issue_sched_test;

  localparam int  CLK_PERIOD = 10;
  localparam int  DEPTH = 4;
  localparam int  REG_W = 5;
  localparam int  TAG_W = 4;
  localparam int  CNT_W = 6;
  localparam int  NV    = 8;

  // Per vector: four instructions {fp,dst,srcA,srcB} oldest first, then
  // four issue cycles, one byte each: {slot0 tag, slot1 tag}, 0 = slot idle.
  localparam logic [95:0] VECS [NV] = '{
    // R1 four independent instructions pair up in order
    {1'b0,5'd1,5'd2,5'd3,  1'b0,5'd4,5'd5,5'd6,  1'b0,5'd7,5'd8,5'd9,  1'b0,5'd10,5'd11,5'd12, 32'h1234_0000},
    // R5 look-ahead: 2 depends on 1, so 3 pairs with 1
    {1'b0,5'd1,5'd0,5'd0,  1'b0,5'd1,5'd1,5'd0,  1'b0,5'd2,5'd0,5'd0,  1'b0,5'd2,5'd2,5'd0,   32'h1324_0000},
    // R2 serial read-after-write chain
    {1'b0,5'd1,5'd0,5'd0,  1'b0,5'd2,5'd1,5'd0,  1'b0,5'd3,5'd2,5'd0,  1'b0,5'd4,5'd3,5'd0,   32'h1020_3040},
    // R4 floating-point operations never share a cycle
    {1'b1,5'd1,5'd2,5'd3,  1'b1,5'd4,5'd5,5'd6,  1'b0,5'd7,5'd8,5'd9,  1'b1,5'd10,5'd11,5'd12, 32'h1320_4000},
    // R3 write-after-read: 3 writes a register 1 reads
    {1'b0,5'd1,5'd2,5'd3,  1'b0,5'd5,5'd1,5'd0,  1'b0,5'd2,5'd6,5'd0,  1'b0,5'd7,5'd8,5'd0,   32'h1423_0000},
    // R3 write-after-write: 3 rewrites what 1 writes and 2 reads
    {1'b0,5'd1,5'd2,5'd3,  1'b0,5'd4,5'd1,5'd0,  1'b0,5'd1,5'd5,5'd0,  1'b0,5'd6,5'd7,5'd0,   32'h1420_3000},
    // R2 register 0 carries no dependency
    {1'b0,5'd0,5'd1,5'd2,  1'b0,5'd3,5'd0,5'd0,  1'b0,5'd0,5'd4,5'd0,  1'b0,5'd5,5'd0,5'd0,   32'h1234_0000},
    // R5 look-ahead reaches the last entry
    {1'b0,5'd1,5'd2,5'd3,  1'b0,5'd2,5'd1,5'd0,  1'b0,5'd3,5'd1,5'd0,  1'b0,5'd4,5'd5,5'd0,   32'h1423_0000}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [REG_W-1:0] in_dst, in_src_a, in_src_b;
  logic             in_fp, in_br;
  logic [TAG_W-1:0] in_tag;
  logic             br_resolve;
  logic             iss0_vld, iss1_vld;
  logic [TAG_W-1:0] iss0_tag, iss1_tag;
  logic [CNT_W-1:0] vwaste_cnt, hwaste_cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_issue_sched #(.DEPTH(DEPTH), .REG_W(REG_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_dst     (in_dst),
    .in_src_a   (in_src_a),
    .in_src_b   (in_src_b),
    .in_fp      (in_fp),
    .in_br      (in_br),
    .in_tag     (in_tag),
    .br_resolve (br_resolve),
    .iss0_vld   (iss0_vld),
    .iss0_tag   (iss0_tag),
    .iss1_vld   (iss1_vld),
    .iss1_tag   (iss1_tag),
    .vwaste_cnt (vwaste_cnt),
    .hwaste_cnt (hwaste_cnt)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] issued();
    return {(iss0_vld ? iss0_tag : 4'h0), (iss1_vld ? iss1_tag : 4'h0)};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; br_resolve = 1'b0;
    in_dst = '0; in_src_a = '0; in_src_b = '0; in_fp = 1'b0; in_br = 1'b0; in_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // f = {br, fp, dst, srcA, srcB}; offered at this negedge, taken at the next edge.
  task automatic push(input logic [16:0] f, input logic [3:0] t);
    in_valid = 1'b1;
    {in_br, in_fp, in_dst, in_src_a, in_src_b} = f;
    in_tag = t;
    @(negedge clk);
  endtask

  // A leading branch issues and freezes issue; then four entries fill the window.
  task automatic load_group(input logic [16:0] g0, g1, g2, g3);
    push({1'b1, 16'h0}, 4'hF);
    push(g0, 4'd1);
    push(g1, 4'd2);
    push(g2, 4'd3);
    push(g3, 4'd4);
    in_valid = 1'b0;
  endtask

  task automatic resolve();
    br_resolve = 1'b1;
    @(negedge clk);
    br_resolve = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R10 reset state
    check("R10 in_ready", {15'd0, in_ready}, 16'd1);
    check("R10 no issue", {8'd0, issued()}, 16'd0);
    check("R10 vwaste", {10'd0, vwaste_cnt}, 16'd0);
    check("R10 hwaste", {10'd0, hwaste_cnt}, 16'd0);

    // Table walk: frozen load, resolve, then four issue cycles.
    for (int v = 0; v < NV; v++) begin
      load_group({1'b0, VECS[v][95:80]}, {1'b0, VECS[v][79:64]},
                 {1'b0, VECS[v][63:48]}, {1'b0, VECS[v][47:32]});
      check($sformatf("R9 full window vec%0d", v), {15'd0, in_ready}, 16'd0);
      resolve();
      for (int c = 0; c < 4; c++) begin
        check($sformatf("R1 R2 R3 R4 R5 vec%0d cycle%0d", v, c),
              {8'd0, issued()}, {8'd0, VECS[v][31 - 8*c -: 8]});
        @(negedge clk);
      end
    end

    // R6 branch at entry 1 pairs with entry 0, then freezes 3 and 4.
    load_group({1'b0,1'b0,5'd1,5'd2,5'd0}, {1'b1,1'b0,5'd0,5'd9,5'd0},
               {1'b0,1'b0,5'd3,5'd4,5'd0}, {1'b0,1'b0,5'd5,5'd6,5'd0});
    resolve();
    check("R6 branch pairs with older", {8'd0, issued()}, 16'h0012);
    @(negedge clk);
    check("R6 frozen after branch", {8'd0, issued()}, 16'h0000);
    @(negedge clk);
    check("R6 still frozen", {8'd0, issued()}, 16'h0000);
    resolve();
    check("R6 resume after resolve", {8'd0, issued()}, 16'h0034);
    @(negedge clk);

    // R6 blocked branch also blocks younger independent entries.
    load_group({1'b0,1'b0,5'd1,5'd2,5'd0}, {1'b1,1'b0,5'd0,5'd1,5'd0},
               {1'b0,1'b0,5'd3,5'd4,5'd0}, {1'b0,1'b0,5'd5,5'd6,5'd0});
    resolve();
    check("R6 no pass over waiting branch", {8'd0, issued()}, 16'h0010);
    @(negedge clk);
    check("R6 branch issues alone", {8'd0, issued()}, 16'h0020);
    @(negedge clk);
    check("R6 frozen after branch 2", {8'd0, issued()}, 16'h0000);
    resolve();
    check("R6 resume 2", {8'd0, issued()}, 16'h0034);
    @(negedge clk);

    // R9 back-pressure: an instruction offered while full is not taken.
    load_group({1'b0,1'b0,5'd1,5'd2,5'd3}, {1'b0,1'b0,5'd4,5'd5,5'd6},
               {1'b0,1'b0,5'd7,5'd8,5'd9}, {1'b0,1'b0,5'd10,5'd11,5'd12});
    push({1'b0,1'b0,5'd13,5'd14,5'd15}, 4'd9);
    push({1'b0,1'b0,5'd13,5'd14,5'd15}, 4'd9);
    check("R9 ready low while full", {15'd0, in_ready}, 16'd0);
    in_valid = 1'b0;
    resolve();
    check("R9 held offer not taken c0", {8'd0, issued()}, 16'h0012);
    @(negedge clk);
    check("R9 held offer not taken c1", {8'd0, issued()}, 16'h0034);
    @(negedge clk);
    check("R9 window drained", {8'd0, issued()}, 16'h0000);

    // R7 R8 counters from a fresh reset.
    do_reset();
    push({1'b1, 16'h0}, 4'hF);
    push({1'b0,1'b0,5'd1,5'd0,5'd0}, 4'd1);
    in_valid = 1'b0;
    check("R8 lone branch counted", {10'd0, hwaste_cnt}, 16'd1);
    check("R7 no stall yet", {10'd0, vwaste_cnt}, 16'd0);
    repeat (5) @(negedge clk);
    check("R7 stall cycles counted", {10'd0, vwaste_cnt}, 16'd5);
    repeat (70) @(negedge clk);
    check("R7 vwaste saturates", {10'd0, vwaste_cnt}, 16'd63);
    resolve();
    check("R6 resumes lone entry", {8'd0, issued()}, 16'h0010);
    for (int n = 0; n < 70; n++) begin
      push({1'b0,1'b0,5'd1,5'd0,5'd0}, 4'd2);
    end
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 hwaste saturates", {10'd0, hwaste_cnt}, 16'd63);
    check("R7 vwaste held at limit", {10'd0, vwaste_cnt}, 16'd63);
    check("R9 ready after drain", {15'd0, in_ready}, 16'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule